// File: doc/BRIEF.md
# Externally Paced DMA Channel Gate

This block sits between a DMA channel's control registers and its data path and decides when the data path may move bytes. Software issues a start command. In the plain mode the channel runs at once. In the external-start mode the command only arms the channel, and the first byte waits for a rising edge on an external start pin.

In the external-pause mode the channel moves a burst of a programmed power-of-two number of bytes and then stops. Each further burst needs a fresh rising edge on an external request pin. A pin that stays high does not release another burst. The transfer ends when the data path reports that the total count is exhausted, so the last burst may be shorter than the others. A halt command stops the channel from any state.

Both pins are asynchronous to the clock. Each one passes through a two-flop synchroniser and an edge detector before the control logic acts on it. The data path reports every byte moved with a strobe. The block drives a run enable back to it.

Top module: `dma_pace_gate`

## Requirements
- R1: While reset is held, and after it is released, `run_en`, `armed`, `paused`, `cs_bit`, `xs_bit`, `xp_bit` and `cnt_clr` are all 0.
- R2: When `sw_start` is accepted in idle with `ext_start_en`=0, `run_en` and `cs_bit` are 1 after the clock edge that samples it, and `xs_bit` stays 0.
- R3: When `sw_start` is accepted with `ext_start_en`=1, the block sets `xs_bit` and `armed`, and `cs_bit` and `run_en` stay 0. `run_en` rises after the third clock edge that samples `start_pin` high following a low level.
- R4: When `xp_bit` is set, `run_en` falls and `paused` rises after the clock edge that takes the 2^L-th `byte_stb` of a burst, where L is the burst size field.
- R5: `burst_log2` is a 4-bit base-2 logarithm of the burst size in bytes. Any value above 10 acts as 10, which gives 1024 bytes.
- R6: A paused channel resumes only on a new rising edge of `req_pin`. `run_en` rises after the third edge that samples the pin high. A pin held high across a pause does not resume the channel. Each resume reloads a full burst.
- R7: `xfer_done` while running returns the block to idle and clears `cs_bit`, `xs_bit` and `xp_bit`. This takes priority over a pause in the same cycle, so a short final burst ends cleanly.
- R8: `sw_halt` returns the block to idle from any state, clears `cs_bit`, `xs_bit` and `xp_bit`, and wins over every other input in the same cycle.
- R9: `cnt_clr` is a one-cycle pulse that follows an accepted `sw_start` only when `ext_pause_en`=1.
- R10: `byte_stb` outside the running state and `sw_start` outside idle have no effect on any output.
- R11: When `xp_bit` is 0, `byte_stb` never pauses the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_start_en | input | 1 | Mode field: first burst waits for the start pin |
| ext_pause_en | input | 1 | Mode field: bursts paced by the request pin |
| burst_log2 | input | 4 | Mode field: log2 of the burst size in bytes |
| sw_start | input | 1 | Software start command pulse |
| sw_halt | input | 1 | Software halt command pulse |
| start_pin | input | 1 | Asynchronous external start pin |
| req_pin | input | 1 | Asynchronous external request pin |
| byte_stb | input | 1 | One byte moved by the data path |
| xfer_done | input | 1 | Data path reports the total count is exhausted |
| run_en | output | 1 | Data path may move bytes |
| armed | output | 1 | Waiting for the external start pin |
| paused | output | 1 | Waiting for a request-pin edge |
| cs_bit | output | 1 | Channel-start state bit |
| xs_bit | output | 1 | External-start enable state bit |
| xp_bit | output | 1 | External-pause enable state bit |
| cnt_clr | output | 1 | Pulse that clears the byte-count register |

## Verification
A table of burst sizes drives the pause mode. It includes the sizes 1, 2 and 8, the largest legal code, and codes above 10. These entries separate a correct power-of-two decode and clamp from an off-by-one count or an unclamped shift. Each table entry also resumes once and measures a second burst. That second burst shows whether the counter reloads, and leaving the pin high afterwards shows whether the resume responds to edges or to levels. Directed sequences then exercise:
- the plain and external-start modes, where the sequences count the synchroniser latency edge by edge;
- a done input that arrives together with the last byte of a burst;
- a halt while paused;
- strobes and start commands that arrive in states where they must be ignored.

// File: rtl/dma_pace_pkg.sv
package dma_pace_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } pace_state_e;

  localparam int PIN_START = 0;
  localparam int PIN_REQ   = 1;
  localparam int NUM_PINS  = 2;
endpackage

// File: rtl/dma_pace_sync.sv
module dma_pace_sync #(
  parameter int NPIN = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPIN-1:0] pin_async,
  output logic [NPIN-1:0] rise
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_async[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end

    assign rise[i] = sync_q & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]); // R6
  end
endmodule

// File: rtl/dma_pace_burst.sv
module dma_pace_burst #(
  parameter int LOG2_W   = 4,
  parameter int MAX_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [LOG2_W-1:0] size_log2,
  input  logic              dec,
  output logic              last
);
  localparam int CNT_W = MAX_LOG2 + 1;

  logic [LOG2_W-1:0] eff_log2;
  logic [CNT_W-1:0]  reload;
  logic [CNT_W-1:0]  cnt_q;

  always_comb begin
    if (int'(size_log2) > MAX_LOG2) eff_log2 = LOG2_W'(MAX_LOG2);
    else                            eff_log2 = size_log2;
    reload = CNT_W'(1) << eff_log2;
  end

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= reload;
    else if (dec)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last = (cnt_q == CNT_W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q != '0)); // R4
  AST_RELOAD_FULL: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q != '0)); // R6
endmodule

// File: rtl/dma_pace_ctrl.sv
module dma_pace_ctrl
  import dma_pace_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sw_start,
  input  logic sw_halt,
  input  logic ext_start_en,
  input  logic ext_pause_en,
  input  logic start_rise,
  input  logic req_rise,
  input  logic byte_stb,
  input  logic xfer_done,
  input  logic burst_last,
  output logic load,
  output logic dec,
  output logic run_en,
  output logic armed,
  output logic paused,
  output logic cs_bit,
  output logic xs_bit,
  output logic xp_bit,
  output logic cnt_clr
);
  pace_state_e state_q, nxt;
  logic run_q, armed_q, paused_q, cs_q, xs_q, xp_q, clr_q;
  logic accept;

  assign accept = (state_q == ST_IDLE) && sw_start && !sw_halt;

  always_comb begin
    nxt = state_q;
    if (sw_halt) nxt = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE:  if (sw_start) nxt = ext_start_en ? ST_ARMED : ST_RUN;
        ST_ARMED: if (start_rise) nxt = ST_RUN;
        ST_RUN: begin
          if (xfer_done) nxt = ST_IDLE;
          else if (byte_stb && burst_last && xp_q) nxt = ST_HOLD;
        end
        ST_HOLD:  if (req_rise) nxt = ST_RUN;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  assign load = (nxt == ST_RUN) && (state_q != ST_RUN);
  assign dec  = (state_q == ST_RUN) && byte_stb && xp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      run_q    <= 1'b0;
      armed_q  <= 1'b0;
      paused_q <= 1'b0;
      cs_q     <= 1'b0;
      xs_q     <= 1'b0;
      xp_q     <= 1'b0;
      clr_q    <= 1'b0;
    end else begin
      state_q  <= nxt;
      run_q    <= (nxt == ST_RUN);
      armed_q  <= (nxt == ST_ARMED);
      paused_q <= (nxt == ST_HOLD);
      clr_q    <= accept && ext_pause_en;
      if (sw_halt || ((state_q == ST_RUN) && xfer_done)) begin
        cs_q <= 1'b0;
        xs_q <= 1'b0;
        xp_q <= 1'b0;
      end else if (accept) begin
        cs_q <= !ext_start_en;
        xs_q <= ext_start_en;
        xp_q <= ext_pause_en;
      end
    end
  end

  assign run_en  = run_q;
  assign armed   = armed_q;
  assign paused  = paused_q;
  assign cs_bit  = cs_q;
  assign xs_bit  = xs_q;
  assign xp_bit  = xp_q;
  assign cnt_clr = clr_q;

  AST_ARMED_WAITS: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !start_rise && !sw_halt) |=> (armed_q && !run_q)); // R3
  AST_HOLD_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    (paused_q && !req_rise && !sw_halt) |=> !run_q); // R6
  AST_DONE_STOPS: assert property (@(posedge clk) disable iff (rst)
    (run_q && xfer_done && !sw_halt) |=> (!run_q && !paused_q)); // R7
  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sw_halt |=> (!run_q && !cs_q && !xs_q && !xp_q)); // R8
  AST_NO_PAUSE_OFF: assert property (@(posedge clk) disable iff (rst)
    (run_q && !xp_q && !xfer_done && !sw_halt) |=> run_q); // R11
endmodule

// File: rtl/dma_pace_gate.sv
module dma_pace_gate
  import dma_pace_pkg::*;
#(
  parameter int LOG2_W   = 4,
  parameter int MAX_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_start_en,
  input  logic              ext_pause_en,
  input  logic [LOG2_W-1:0] burst_log2,
  input  logic              sw_start,
  input  logic              sw_halt,
  input  logic              start_pin,
  input  logic              req_pin,
  input  logic              byte_stb,
  input  logic              xfer_done,
  output logic              run_en,
  output logic              armed,
  output logic              paused,
  output logic              cs_bit,
  output logic              xs_bit,
  output logic              xp_bit,
  output logic              cnt_clr
);
  logic [NUM_PINS-1:0] pins, rises;
  logic load, dec, last;

  always_comb begin
    pins            = '0;
    pins[PIN_START] = start_pin;
    pins[PIN_REQ]   = req_pin;
  end

  dma_pace_sync #(.NPIN(NUM_PINS)) u_sync (
    .clk(clk), .rst(rst), .pin_async(pins), .rise(rises)
  );

  dma_pace_burst #(.LOG2_W(LOG2_W), .MAX_LOG2(MAX_LOG2)) u_burst (
    .clk(clk), .rst(rst), .load(load), .size_log2(burst_log2),
    .dec(dec), .last(last)
  );

  dma_pace_ctrl u_ctrl (
    .clk(clk), .rst(rst), .sw_start(sw_start), .sw_halt(sw_halt),
    .ext_start_en(ext_start_en), .ext_pause_en(ext_pause_en),
    .start_rise(rises[PIN_START]), .req_rise(rises[PIN_REQ]),
    .byte_stb(byte_stb), .xfer_done(xfer_done), .burst_last(last),
    .load(load), .dec(dec), .run_en(run_en), .armed(armed),
    .paused(paused), .cs_bit(cs_bit), .xs_bit(xs_bit), .xp_bit(xp_bit),
    .cnt_clr(cnt_clr)
  );
endmodule

// File: tb/dma_pace_gate_tb.sv
`timescale 1ns/1ps
module dma_pace_gate_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_start_en = 0, ext_pause_en = 0;
  logic [3:0] burst_log2 = '0;
  logic sw_start = 0, sw_halt = 0, start_pin = 0, req_pin = 0;
  logic byte_stb = 0, xfer_done = 0;
  logic run_en, armed, paused, cs_bit, xs_bit, xp_bit, cnt_clr;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_pace_gate u_dut (
    .clk(clk), .rst(rst), .ext_start_en(ext_start_en), .ext_pause_en(ext_pause_en),
    .burst_log2(burst_log2), .sw_start(sw_start), .sw_halt(sw_halt),
    .start_pin(start_pin), .req_pin(req_pin), .byte_stb(byte_stb),
    .xfer_done(xfer_done), .run_en(run_en), .armed(armed), .paused(paused),
    .cs_bit(cs_bit), .xs_bit(xs_bit), .xp_bit(xp_bit), .cnt_clr(cnt_clr)
  );

  // {burst_log2, expected burst length}: R5 decode and clamp
  localparam int VEC [6][2] = '{'{0, 1}, '{1, 2}, '{3, 8}, '{10, 1024},
                                '{11, 1024}, '{15, 1024}};

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic do_start(); sw_start = 1; tick(); sw_start = 0; endtask
  task automatic do_halt();  sw_halt = 1;  tick(); sw_halt = 0;  endtask

  task automatic burst(output int n);
    n = 0;
    while (run_en && n < 3000) begin
      byte_stb = 1; tick(); n++;
    end
    byte_stb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    tick();
    chk("R1 run_en in reset", run_en, 0);
    chk("R1 bits in reset", {cs_bit, xs_bit, xp_bit, armed, paused, cnt_clr}, 0);
    tick(); rst = 0; tick();
    chk("R1 idle after reset", {run_en, cs_bit, xs_bit, xp_bit, armed, paused, cnt_clr}, 0);

    // Table walk: burst length, resume, reload, held-high pin
    foreach (VEC[i]) begin
      burst_log2 = 4'(VEC[i][0]); ext_pause_en = 1; ext_start_en = 0;
      do_start();
      chk("R9 cnt_clr pulse", cnt_clr, 1);
      chk("R4 xp_bit set", xp_bit, 1);
      burst(n);
      chk($sformatf("R5 R4 burst log2=%0d", VEC[i][0]), n, VEC[i][1]);
      chk("R4 paused", paused, 1);
      req_pin = 1; tick(); tick();
      chk("R6 no resume before sync", run_en, 0);
      tick();
      chk("R6 resume on edge", run_en, 1);
      burst(n);
      chk("R6 reload full burst", n, VEC[i][1]);
      repeat (6) tick();
      chk("R6 held pin no resume", run_en, 0);
      req_pin = 0;
      do_halt();
      chk("R8 halt from pause", {paused, xp_bit, run_en}, 0);
    end

    // Plain start, no pause
    ext_pause_en = 0; ext_start_en = 0; burst_log2 = 0;
    do_start();
    chk("R2 run_en", run_en, 1);
    chk("R2 cs/xs bits", {cs_bit, xs_bit}, 2'b10);
    chk("R9 no cnt_clr without pause", cnt_clr, 0);
    repeat (40) begin byte_stb = 1; tick(); end
    byte_stb = 0;
    chk("R11 never pauses", {run_en, paused}, 2'b10);
    ext_start_en = 1; do_start();
    chk("R10 start while busy ignored", {run_en, cs_bit, xs_bit, armed}, 4'b1100);
    xfer_done = 1; tick(); xfer_done = 0;
    chk("R7 done to idle", {run_en, cs_bit, xs_bit}, 0);

    // External start
    ext_start_en = 1;
    do_start();
    chk("R3 armed no run", {armed, run_en, cs_bit, xs_bit}, 4'b1001);
    repeat (5) begin byte_stb = 1; tick(); end
    byte_stb = 0;
    chk("R10 strobes while armed", {armed, run_en, paused}, 3'b100);
    start_pin = 1; tick(); tick();
    chk("R3 waits for sync", run_en, 0);
    tick();
    chk("R3 runs after third edge", {run_en, armed}, 2'b10);
    start_pin = 0;
    do_halt();
    chk("R8 halt from run", {run_en, cs_bit, xs_bit, xp_bit}, 0);

    // Done wins over pause
    ext_start_en = 0; ext_pause_en = 1; burst_log2 = 0;
    do_start();
    byte_stb = 1; xfer_done = 1; tick(); byte_stb = 0; xfer_done = 0;
    chk("R7 done beats pause", {run_en, paused, xp_bit}, 0);

    // Short final burst
    burst_log2 = 3;
    do_start();
    repeat (3) begin byte_stb = 1; tick(); end
    byte_stb = 0;
    chk("R7 mid burst still running", run_en, 1);
    xfer_done = 1; tick(); xfer_done = 0;
    chk("R7 short final burst ends", {run_en, paused}, 0);

    // Halt while paused, then request edge ignored
    burst_log2 = 1;
    do_start();
    burst(n);
    chk("R4 two-byte burst", n, 2);
    do_halt();
    req_pin = 1; repeat (4) tick(); req_pin = 0;
    chk("R8 no resume after halt", {run_en, paused}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule